// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous on-chip request port and an external byte-wide asynchronous static RAM with 32,768 locations. It takes one read or one write at a time and turns it into the chip-select, output-enable and write-enable strobe pattern the memory expects. Each phase of that pattern lasts a set number of system clock cycles. Each count is a parameter, rounded up from the memory's minimum access, pulse-width, data-setup and bus-turnaround times at the chosen clock.

A client presents a request with `req_valid` and holds it until `req_ready` is seen high at a rising edge. The controller is ready only when it is idle, so a request made while it is busy simply waits. Reads return one byte with a single-cycle `rsp_valid` pulse. Writes are ended by the write-enable strobe, and the output enable stays high for the whole write. The controller starts driving the data bus only after a turnaround wait that begins when write enable falls, so it never drives against a memory that is still releasing its outputs.

The external data bus is split into an input, an output and an active-high drive enable. A pad cell outside this block merges them into the real bidirectional pins.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While idle, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, and `mem_dq_oe` is 0. Idle is the state after reset.
- R2: After a read is accepted at a clock edge, `mem_ce_n` and `mem_oe_n` are 0 and `mem_we_n` is 1 for exactly RD_ACC_CYC cycles. During those cycles `mem_addr` carries the accepted address.
- R3: The read byte on `mem_dq_in` is registered at the end of the last access cycle. It appears on `rsp_rdata` with `rsp_valid` high for one cycle, RD_ACC_CYC+1 cycles after the accepting edge, and the controller is idle one cycle later.
- R4: After a write is accepted, the strobes follow three phases. First come WR_SETUP_CYC cycles with `mem_ce_n`=0 and `mem_we_n`=1. Next come WR_PULSE_CYC cycles with `mem_ce_n`=0 and `mem_we_n`=0. Last come WR_RECOV_CYC cycles with both high. The controller is then idle again. `mem_oe_n` stays 1 throughout.
- R5: `mem_dq_oe` is 1 only during a write. It stays 0 for the first WR_TURN_CYC cycles of the write-enable pulse, is 1 for the rest of the pulse and for the recovery phase, and `mem_dq_out` then carries the accepted write byte.
- R6: `mem_oe_n` and `mem_we_n` are never both 0.
- R7: `mem_addr` does not change while `mem_ce_n` stays 0.
- R8: `req_ready` is 0 for every cycle of a read or write in progress. A request held valid during that time is accepted once the controller is idle again, and it is served correctly.
- R9: `rsp_valid` is never high on two consecutive cycles and never high during a write.
- R10: `rsp_rdata` keeps the last read byte until the next read completes. Later writes and bus activity do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request taken at this edge if valid |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Last read byte |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads, active high |
| mem_dq_in | input | 8 | Byte returned from the data pads |

## Verification
Results are counted from the rising edge that accepts a request. The read response is due on the RD_ACC_CYC+1-th edge after that. The write drive enable is due WR_SETUP_CYC+WR_TURN_CYC+1 edges after acceptance. Ready returns after the sum of the three write phases plus one edge. For every accepted request the bench counts falling edges from that acceptance and records the strobe, address, data and handshake values at each one. It compares each recorded value with the cycle-indexed window the requirements give, so an output that arrives one cycle early or late is flagged. The bench's memory model returns a poison byte until the access time has passed, so a capture taken too early is caught as a data mismatch.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_RECOVER = 3'd5
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             done
);

  logic [CNT_W-1:0] count_d;

  always_comb begin
    if (clr) count_d = '0;
    else     count_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  assign done = (count == (limit - CNT_W'(1)));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_go,
  input  logic       req_write,
  input  logic       phase_done,
  output seq_state_t state
);

  seq_state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (req_go) state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
      end
      ST_RD_ACCESS:  if (phase_done) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_IDLE;
      ST_WR_SETUP:   if (phase_done) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (phase_done) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (phase_done) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
  import sram_seq_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int WR_TURN_CYC = 2
) (
  input  seq_state_t       state,
  input  logic [CNT_W-1:0] count,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             ready,
  output logic             rd_pulse
);

  always_comb begin
    ce_n     = 1'b1;
    oe_n     = 1'b1;
    we_n     = 1'b1;
    dq_oe    = 1'b0;
    ready    = 1'b0;
    rd_pulse = 1'b0;
    unique case (state)
      ST_IDLE:       ready = 1'b1;
      ST_RD_ACCESS: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_RD_CAPTURE: rd_pulse = 1'b1;
      ST_WR_SETUP:   ce_n = 1'b0;
      ST_WR_PULSE: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        dq_oe = (count >= CNT_W'(WR_TURN_CYC));
      end
      ST_WR_RECOVER: dq_oe = 1'b1;
      default:       ready = 1'b0;
    endcase
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int RD_ACC_CYC   = 4,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 4,
  parameter int WR_TURN_CYC  = 2,
  parameter int WR_RECOV_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int PH_MAX = max2(max2(RD_ACC_CYC, WR_SETUP_CYC),
                               max2(WR_PULSE_CYC, WR_RECOV_CYC));
  localparam int CNT_W  = $clog2(PH_MAX + 1);

  logic              rst_meta, rst_sync_n;
  seq_state_t        state;
  logic [CNT_W-1:0]  count, phase_limit;
  logic              phase_done, timer_clr, accept, capture_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign accept     = req_valid && req_ready;
  assign capture_en = (state == ST_RD_ACCESS) && phase_done;
  assign timer_clr  = (state == ST_IDLE) || (state == ST_RD_CAPTURE) || phase_done;

  always_comb begin
    unique case (state)
      ST_RD_ACCESS:  phase_limit = CNT_W'(RD_ACC_CYC);
      ST_WR_SETUP:   phase_limit = CNT_W'(WR_SETUP_CYC);
      ST_WR_PULSE:   phase_limit = CNT_W'(WR_PULSE_CYC);
      ST_WR_RECOVER: phase_limit = CNT_W'(WR_RECOV_CYC);
      default:       phase_limit = CNT_W'(1);
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (timer_clr),
    .limit (phase_limit),
    .count (count),
    .done  (phase_done)
  );

  sram_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_go     (req_valid),
    .req_write  (req_write),
    .phase_done (phase_done),
    .state      (state)
  );

  sram_strobe_decode #(.CNT_W(CNT_W), .WR_TURN_CYC(WR_TURN_CYC)) u_dec (
    .state    (state),
    .count    (count),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .dq_oe    (mem_dq_oe),
    .ready    (req_ready),
    .rd_pulse (rsp_valid)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     rdata_q <= '0;
    else if (capture_en) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

  initial begin
    if (RD_ACC_CYC < 1 || WR_SETUP_CYC < 1 || WR_RECOV_CYC < 1 ||
        WR_TURN_CYC < 1 || WR_PULSE_CYC <= WR_TURN_CYC)
      $error("sram_seq_ctrl: phase counts out of range");
  end

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W       = 15,
  parameter int WR_PULSE_CYC = 4,
  parameter int WR_TURN_CYC  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic [7:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (mem_we_n)         low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_we_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && low_cnt != 8'd0) |-> (low_cnt >= 8'(WR_PULSE_CYC)));

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && low_cnt < 8'(WR_TURN_CYC)) |-> !mem_dq_oe);

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_no_oe_we_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_rsp_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || mem_dq_oe) |-> !rsp_valid);

endmodule

bind sram_seq_ctrl sram_seq_chk #(
  .ADDR_W       (ADDR_W),
  .WR_PULSE_CYC (WR_PULSE_CYC),
  .WR_TURN_CYC  (WR_TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;

  localparam int RD = 4;
  localparam int SU = 1;
  localparam int PW = 4;
  localparam int TN = 2;
  localparam int RC = 1;
  localparam int WR_TOTAL = SU + PW + RC;

  // vector: {write, address, data}; for reads data is the expected byte
  localparam logic [23:0] VEC [0:7] = '{
    {1'b1, 15'h0000, 8'hA5},
    {1'b1, 15'h7FFF, 8'h3C},
    {1'b1, 15'h1234, 8'h0F},
    {1'b0, 15'h0000, 8'hA5},
    {1'b0, 15'h7FFF, 8'h3C},
    {1'b1, 15'h0000, 8'h5A},
    {1'b0, 15'h0000, 8'h5A},
    {1'b0, 15'h1234, 8'h0F}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;

  sram_seq_ctrl #(
    .RD_ACC_CYC(RD), .WR_SETUP_CYC(SU), .WR_PULSE_CYC(PW),
    .WR_TURN_CYC(TN), .WR_RECOV_CYC(RC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model: 256 bytes indexed by low address bits, slow to respond
  logic [7:0] model [0:255];
  int acc_cnt = 0;
  initial for (int i = 0; i < 256; i++) model[i] = 8'h00;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n) acc_cnt <= acc_cnt + 1;
    else                        acc_cnt <= 0;
  end
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) model[mem_addr[7:0]] <= mem_dq_out;
  end
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && acc_cnt >= RD - 1) mem_dq_in = model[mem_addr[7:0]];
    else                                             mem_dq_in = 8'hEE;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_write(input logic [14:0] a, input logic [7:0] d);
    int we_bad = 0, ce_bad = 0, oe_bad = 0, dq_bad = 0, dat_bad = 0, rdy_bad = 0, rsp_bad = 0;
    send(1'b1, a, d);
    for (int k = 1; k <= WR_TOTAL + 1; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (mem_we_n != !(k >= SU + 1 && k <= SU + PW)) we_bad++;
      if (mem_ce_n != !(k <= SU + PW)) ce_bad++;
      if (!mem_oe_n) oe_bad++;
      if (mem_dq_oe != (k >= SU + 1 + TN && k <= WR_TOTAL)) dq_bad++;
      if (mem_dq_oe && (mem_dq_out != d || mem_addr != a)) dat_bad++;
      if (req_ready != (k == WR_TOTAL + 1)) rdy_bad++;
      if (rsp_valid) rsp_bad++;
    end
    chk(we_bad == 0,  "R4 write-enable pulse window", we_bad, 0);
    chk(ce_bad == 0,  "R4 chip-select window", ce_bad, 0);
    chk(oe_bad == 0,  "R4 output enable held high in write", oe_bad, 0);
    chk(dq_bad == 0,  "R5 drive enable after turnaround", dq_bad, 0);
    chk(dat_bad == 0, "R5 driven byte and address", dat_bad, 0);
    chk(rdy_bad == 0, "R8 ready low while writing", rdy_bad, 0);
    chk(rsp_bad == 0, "R9 no response on write", rsp_bad, 0);
  endtask

  task automatic finish_read(input logic [14:0] a, input logic [7:0] exp);
    int str_bad = 0, adr_bad = 0, rsp_cnt = 0, rdy_bad = 0;
    logic [7:0] got = 8'h00;
    for (int k = 1; k <= RD + 1; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (k <= RD) begin
        if (mem_ce_n || mem_oe_n || !mem_we_n || mem_dq_oe) str_bad++;
        if (mem_addr != a) adr_bad++;
      end
      if (req_ready) rdy_bad++;
      if (rsp_valid) begin
        rsp_cnt++;
        if (k != RD + 1) rsp_cnt += 10;
        got = rsp_rdata;
      end
    end
    chk(str_bad == 0, "R2 read strobes", str_bad, 0);
    chk(adr_bad == 0, "R2 read address held", adr_bad, 0);
    chk(rsp_cnt == 1, "R3 single valid pulse at latency", rsp_cnt, 1);
    chk(got == exp,   "R3 read data", got, exp);
    chk(rdy_bad == 0, "R8 ready low while reading", rdy_bad, 0);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R3 idle after response", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int waitn;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    chk(!rsp_valid && rsp_rdata == 8'h00, "R1 response idle in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][23]) run_write(VEC[v][22:8], VEC[v][7:0]);
      else begin
        send(1'b0, VEC[v][22:8], VEC[v][7:0]);
        finish_read(VEC[v][22:8], VEC[v][7:0]);
      end
    end

    // R6 / R1: idle quiet after traffic
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle strobes",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

    // R8: read held valid behind a write is not lost
    send(1'b1, 15'h0042, 8'hC3);
    @(negedge clk);
    req_write = 1'b0;
    waitn = 0;
    while (!req_ready) begin
      waitn++;
      @(negedge clk);
    end
    chk(waitn == WR_TOTAL, "R8 backpressure length", waitn, WR_TOTAL);
    @(posedge clk);
    finish_read(15'h0042, 8'hC3);

    // R10: a following write leaves the read byte in place
    run_write(15'h0043, 8'h11);
    chk(rsp_rdata == 8'hC3, "R10 read byte held across write", rsp_rdata, 8'hC3);
    send(1'b0, 15'h0043, 8'h11);
    finish_read(15'h0043, 8'h11);

    // R6: second turnaround case at top address with all-ones data
    run_write(15'h7FFF, 8'hFF);
    send(1'b0, 15'h7FFF, 8'hFF);
    finish_read(15'h7FFF, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule